// File: doc/BRIEF.md
# MDIO Management Master

This block lets software run clause-22 management transactions toward Ethernet PHYs over a two-wire serial bus: a management clock (MDC) and a shared data line (MDIO). Software sees six 32-bit registers on a simple synchronous register port. It picks the target by storing a PHY number and a register number. It starts a write by storing a 16-bit data word. It starts a read by taking a command bit from 0 to 1. It then polls an indication register until the frame is over.

Each frame is 64 MDC periods long and is sent MSB first. It opens with 32 preamble ones and a `01` start field. The opcode follows (`01` write, `10` read), then the 5-bit PHY number and the 5-bit register number. Next comes a 2-bit turnaround field and, last, 16 data bits. On a read the master stops driving the line from the turnaround onward and shifts in the PHY's reply. MDC is derived from the system clock by a divide ratio picked from a fixed table. The MDIO pin is split into output, output-enable and input for a pad cell outside the block.

Top module: `mdio_master`

## Requirements
- R1: Registers sit at word index 0 configuration, 1 command, 2 address, 3 data-out, 4 data-in, 5 indication. The address register reads back the PHY number in bits 12:8 and the register number in bits 4:0, with all other bits zero. The data-out register reads back the last accepted write word in bits 15:0.
- R2: A register-port write to data-out, while idle, starts a write frame. MDIO carries, MSB first: 32 ones, `01`, `01`, PHY[4:0], REG[4:0], `10`, then the 16 data bits. The output is enabled for all 64 bits.
- R3: A read starts only when command bit 0 is written with 1 while its stored value is 0. Writing 1 over a stored 1 starts nothing.
- R4: A read frame carries 32 ones, `01`, `10`, PHY and REG. The output enable is off for the last 18 bits (turnaround and data). The 16 bits sampled from the PHY, MSB first, land in data-in bits 15:0 when the frame ends.
- R5: Indication bit 0 (busy) is high for exactly 64 × ratio clock cycles per frame. Indication bit 2 (not-valid) rises together with busy when a read launches and clears when that read ends.
- R6: Configuration bits 2:0 select the MDC divide ratio: select values 0 to 7 give 4, 4, 6, 8, 10, 14, 20 and 28 clock cycles per MDC period. The ratio is captured when a frame launches.
- R7: MDIO output and enable change only while MDC is low, that is at falling MDC edges. While no frame runs, MDC is low and the line is released.
- R8: A data-out write or a read launch that arrives while busy is ignored. The running frame, the stored write word and not-valid are all left as they were.
- R9: A configuration write with bit 31 set aborts any frame on the next clock edge. Busy and not-valid clear and the line is released, and MDC is low one cycle later.
- R10: While rst_n is low, MDC is low, the line is released and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word index for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench builds the block with its default parameters: a 32-bit preamble, a 4-bit divider counter and a 3-bit register index. With these, every one of the eight divide selects can run a full frame, and the bench checks each frame's busy length against 64 × ratio. Reads run at the fastest ratio, so many PHY/register pairs fit the budget, including numbers 0 and 31. A PHY responder returns a value computed from the pair. Aborts by soft reset and by rst_n are applied in the middle of frames to reach the release and idle corner cases.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int SEL_W   = 3;
  localparam int PHY_W   = 5;
  localparam int DATA_W  = 16;

  localparam int IDX_CFG = 0;
  localparam int IDX_CMD = 1;
  localparam int IDX_ADR = 2;
  localparam int IDX_DAT = 3;
  localparam int IDX_STS = 4;
  localparam int IDX_IND = 5;

  localparam int CFG_RST_BIT = 31;
  localparam int IND_BUSY    = 0;
  localparam int IND_NV      = 2;
  localparam int ADR_PHY_LSB = 8;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  // system clocks per MDC period for each clock select value
  function automatic logic [5:0] mdc_ratio(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0, 3'd1: mdc_ratio = 6'd4;
      3'd2:       mdc_ratio = 6'd6;
      3'd3:       mdc_ratio = 6'd8;
      3'd4:       mdc_ratio = 6'd10;
      3'd5:       mdc_ratio = 6'd14;
      3'd6:       mdc_ratio = 6'd20;
      default:    mdc_ratio = 6'd28;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
  import mdio_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic [5:0]       ratio;
  logic             tick;

  assign ratio    = mdc_ratio(sel);
  assign half_m1  = CNT_W'(ratio >> 1) - CNT_W'(1);
  assign tick     = run && (cnt >= half_m1);
  assign rise_stb = tick && !mdc;
  assign fall_stb = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic              is_read,
  input  logic [PHY_W-1:0]  phy,
  input  logic [PHY_W-1:0]  regn,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              active,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              frame_end,
  output logic [DATA_W-1:0] rx_data
);
  localparam int FRAME_LEN = PRE_LEN + 4 + 2 * PHY_W + 2 + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA_POS    = FRAME_LEN - DATA_W - 2;
  localparam int RX_POS    = FRAME_LEN - DATA_W;

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic rd, input logic [PHY_W-1:0] p, input logic [PHY_W-1:0] r,
    input logic [DATA_W-1:0] d);
    build_frame = {{PRE_LEN{1'b1}}, 2'b01, (rd ? OP_READ : OP_WRITE), p, r,
                   (rd ? 2'b11 : 2'b10), (rd ? {DATA_W{1'b1}} : d)};
  endfunction

  logic [FRAME_LEN-1:0] shreg;
  logic [IDX_W-1:0]     idx;
  logic                 rd_mode;
  logic                 released;

  assign released  = rd_mode && (idx >= IDX_W'(TA_POS));
  assign mdio_o    = active & shreg[FRAME_LEN-1];
  assign mdio_oe   = active & !released;
  assign frame_end = active && fall_stb && (idx == IDX_W'(FRAME_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      shreg   <= '0;
      idx     <= '0;
      rd_mode <= 1'b0;
      rx_data <= '0;
    end else if (abort) begin
      active  <= 1'b0;
      idx     <= '0;
    end else if (!active) begin
      if (start) begin
        active  <= 1'b1;
        rd_mode <= is_read;
        idx     <= '0;
        shreg   <= build_frame(is_read, phy, regn, wdata);
      end
    end else begin
      if (rise_stb && rd_mode && (idx >= IDX_W'(RX_POS)))
        rx_data <= {rx_data[DATA_W-2:0], mdio_i};
      if (frame_end) begin
        active <= 1'b0;
        idx    <= '0;
      end else if (fall_stb) begin
        shreg <= {shreg[FRAME_LEN-2:0], 1'b1};
        idx   <= idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int PRE_LEN = 32,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(IDX_CFG);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(IDX_CMD);
  localparam logic [ADDR_W-1:0] A_ADR = ADDR_W'(IDX_ADR);
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(IDX_DAT);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(IDX_STS);
  localparam logic [ADDR_W-1:0] A_IND = ADDR_W'(IDX_IND);

  logic [SEL_W-1:0]  cfg_sel, run_sel;
  logic              cmd_rd;
  logic [PHY_W-1:0]  phy_q, regn_q;
  logic [DATA_W-1:0] wdat_q, sts_q;
  logic              notvalid_q;

  logic              busy, frame_end, rise_stb, fall_stb;
  logic [DATA_W-1:0] rx_data;

  // named request events
  logic hit_cfg, hit_cmd, hit_adr, hit_dat;
  logic soft_rst, wr_req, rd_req, launch;

  wire unused_wdata = ^{reg_wdata[30:ADR_PHY_LSB+PHY_W], reg_wdata[ADR_PHY_LSB-1:PHY_W]};

  assign hit_cfg  = reg_we && (reg_addr == A_CFG);
  assign hit_cmd  = reg_we && (reg_addr == A_CMD);
  assign hit_adr  = reg_we && (reg_addr == A_ADR);
  assign hit_dat  = reg_we && (reg_addr == A_DAT);
  assign soft_rst = hit_cfg && reg_wdata[CFG_RST_BIT];
  assign wr_req   = hit_dat && !busy;
  assign rd_req   = hit_cmd && reg_wdata[0] && !cmd_rd && !busy;
  assign launch   = wr_req || rd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_sel    <= '0;
      run_sel    <= '0;
      cmd_rd     <= 1'b0;
      phy_q      <= '0;
      regn_q     <= '0;
      wdat_q     <= '0;
      sts_q      <= '0;
      notvalid_q <= 1'b0;
    end else begin
      if (hit_cfg) cfg_sel <= reg_wdata[SEL_W-1:0];
      if (hit_cmd) cmd_rd  <= reg_wdata[0];
      if (hit_adr) begin
        phy_q  <= reg_wdata[ADR_PHY_LSB +: PHY_W];
        regn_q <= reg_wdata[PHY_W-1:0];
      end
      if (wr_req) wdat_q <= reg_wdata[DATA_W-1:0];
      if (launch) run_sel <= cfg_sel;
      if (frame_end && notvalid_q) sts_q <= rx_data;
      if (soft_rst)       notvalid_q <= 1'b0;
      else if (rd_req)    notvalid_q <= 1'b1;
      else if (frame_end) notvalid_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG: reg_rdata[SEL_W-1:0] = cfg_sel;
      A_CMD: reg_rdata[0] = cmd_rd;
      A_ADR: begin
        reg_rdata[ADR_PHY_LSB +: PHY_W] = phy_q;
        reg_rdata[PHY_W-1:0]            = regn_q;
      end
      A_DAT: reg_rdata[DATA_W-1:0] = wdat_q;
      A_STS: reg_rdata[DATA_W-1:0] = sts_q;
      A_IND: begin
        reg_rdata[IND_BUSY] = busy;
        reg_rdata[IND_NV]   = notvalid_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  mdio_clk_div #(.CNT_W(CNT_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .sel      (run_sel),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_seq #(.PRE_LEN(PRE_LEN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (soft_rst),
    .start     (launch),
    .is_read   (rd_req),
    .phy       (phy_q),
    .regn      (regn_q),
    .wdata     (reg_wdata[DATA_W-1:0]),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .mdio_i    (mdio_i),
    .active    (busy),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .frame_end (frame_end),
    .rx_data   (rx_data)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst_n,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic busy,
  input logic notvalid,
  input logic read_start,
  input logic soft_rst,
  input logic data_req
);
  // R7
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R7
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !mdc);

  // R5
  rd_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_start |=> (busy && notvalid));

  // R5
  nv_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notvalid |-> busy);

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && !notvalid && !mdio_oe));

  // R8
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && data_req && !soft_rst && !mdc) |=> (busy && $stable(mdio_o)));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .busy       (busy),
  .notvalid   (notvalid_q),
  .read_start (rd_req),
  .soft_rst   (soft_rst),
  .data_req   (hit_dat)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  wire  [31:0] reg_rdata;
  wire         mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #4 clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int ratio_tbl [8] = '{4, 4, 6, 8, 10, 14, 20, 28};

  // bus monitor and PHY responder
  logic        mdc_prev = 1'b0, o_prev = 1'b0, oe_prev = 1'b0;
  int          cap_n = 0;
  int          hold_bad = 0;
  logic [63:0] cap_o = '0, cap_oe = '0;
  logic [15:0] resp = '0;

  always @(negedge clk) begin
    int nxt;
    if (mdc && !mdc_prev) begin
      if (cap_n < 64) begin
        cap_o[63-cap_n]  = mdio_o;
        cap_oe[63-cap_n] = mdio_oe;
      end
      nxt = cap_n + 1;
      if (nxt >= 48 && nxt < 64) mdio_i = resp[63-nxt];
      else if (nxt == 47)        mdio_i = 1'b0;
      else                       mdio_i = 1'b1;
      cap_n = cap_n + 1;
    end
    if (mdc && mdc_prev && (mdio_o !== o_prev || mdio_oe !== oe_prev))
      hold_bad = hold_bad + 1;
    mdc_prev = mdc;
    o_prev   = mdio_o;
    oe_prev  = mdio_oe;
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] v;
    cyc = 0;
    rd(3'd5, v);
    while (v[0] && cyc < 5000) begin
      cyc++;
      @(negedge clk);
      rd(3'd5, v);
    end
  endtask

  function automatic logic [15:0] phy_reply(input logic [4:0] p, input logic [4:0] r);
    logic [15:0] x;
    x = {p, r, 6'd0} * 16'd40503;
    return x ^ 16'hA5C3 ^ {11'd0, p};
  endfunction

  initial begin
    logic [31:0] v;
    int cyc;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "mdc in reset", {63'd0, mdc}, 64'd0);
    check("R10", "oe in reset", {63'd0, mdio_oe}, 64'd0);
    rd(3'd5, v); check("R10", "ind in reset", {32'd0, v}, 64'd0);
    rd(3'd0, v); check("R10", "cfg in reset", {32'd0, v}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 address layout
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); check("R1", "addr readback all ones", {32'd0, v}, 64'h1F1F);
    wr(3'd2, 32'h0000_1A13);
    rd(3'd2, v); check("R1", "addr readback", {32'd0, v}, 64'h1A13);

    // R2 R6 write frames across every clock select
    for (int s = 0; s < 8; s++) begin
      logic [4:0]  p, r;
      logic [15:0] d;
      p = 5'(s * 3 + 1); r = 5'(s * 5 + 2); d = 16'(16'h1357 * (s + 1) + s);
      wr(3'd0, {29'd0, 3'(s)});
      wr(3'd2, {19'd0, p, 3'd0, r});
      cap_n = 0; hold_bad = 0;
      wr(3'd3, {16'hDEAD, d});
      wait_idle(cyc);
      check("R6", $sformatf("busy cycles sel %0d", s), 64'(cyc), 64'(64 * ratio_tbl[s]));
      check("R2", $sformatf("write frame sel %0d", s), cap_o,
            {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d});
      check("R2", "write frame enable", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
      check("R7", "hold while mdc high", 64'(hold_bad), 64'd0);
      @(negedge clk);
      check("R7", "idle mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);
      rd(3'd3, v); check("R1", "data-out readback", {32'd0, v}, {48'd0, d});
    end

    // R3 R4 R5 reads at the fastest ratio
    wr(3'd0, 32'd0);
    for (int k = 0; k < 6; k++) begin
      logic [4:0] p, r;
      p = (k == 0) ? 5'd0 : (k == 1) ? 5'd31 : 5'(k * 7);
      r = (k == 0) ? 5'd31 : (k == 1) ? 5'd0 : 5'(k * 11 + 3);
      resp = phy_reply(p, r);
      wr(3'd2, {19'd0, p, 3'd0, r});
      cap_n = 0; hold_bad = 0;
      wr(3'd1, 32'd0);
      wr(3'd1, 32'd1);
      rd(3'd5, v); check("R5", "busy+notvalid at read launch", {32'd0, v}, 64'd5);
      wait_idle(cyc);
      check("R5", "read busy cycles", 64'(cyc), 64'd256);
      rd(3'd5, v); check("R5", "ind after read", {32'd0, v}, 64'd0);
      rd(3'd4, v); check("R4", "read data", {32'd0, v}, {48'd0, resp});
      check("R4", "read header", cap_o >> 18, {32'hFFFF_FFFF, 2'b01, 2'b10, p, r});
      check("R4", "read enable", cap_oe, 64'hFFFF_FFFF_FFFC_0000);
      check("R7", "hold during read", 64'(hold_bad), 64'd0);
    end

    // R3 writing 1 over a stored 1 starts nothing
    cap_n = 0;
    wr(3'd1, 32'd1);
    rd(3'd5, v); check("R3", "no launch on level", {32'd0, v}, 64'd0);
    repeat (40) @(negedge clk);
    check("R3", "no frame on level", 64'(cap_n), 64'd0);

    // R8 requests while busy are ignored
    wr(3'd2, {19'd0, 5'd9, 3'd0, 5'd4});
    cap_n = 0;
    wr(3'd3, 32'h0000_C0DE);
    repeat (20) @(negedge clk);
    wr(3'd3, 32'h0000_BEEF);
    wr(3'd1, 32'd0);
    wr(3'd1, 32'd1);
    rd(3'd5, v); check("R8", "no notvalid from busy read", {32'd0, v}, 64'd1);
    rd(3'd3, v); check("R8", "data-out kept", {32'd0, v}, 64'hC0DE);
    wait_idle(cyc);
    repeat (100) @(negedge clk);
    check("R8", "single frame", 64'(cap_n), 64'd64);
    check("R8", "frame data kept", cap_o,
          {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd9, 5'd4, 2'b10, 16'hC0DE});

    // R9 soft reset in the middle of a slow read
    wr(3'd0, 32'd7);
    wr(3'd1, 32'd0);
    wr(3'd1, 32'd1);
    repeat (300) @(negedge clk);
    wr(3'd0, 32'h8000_0000);
    rd(3'd5, v); check("R9", "ind after abort", {32'd0, v}, 64'd0);
    check("R9", "line released", {63'd0, mdio_oe}, 64'd0);
    @(negedge clk);
    check("R9", "mdc low", {63'd0, mdc}, 64'd0);
    rd(3'd0, v); check("R9", "cfg after abort", {32'd0, v}, 64'd0);
    cap_n = 0;
    wr(3'd3, 32'h0000_5A5A);
    wait_idle(cyc);
    check("R9", "frame after abort", 64'(cyc), 64'd256);
    check("R9", "frame after abort data", cap_o,
          {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd9, 5'd4, 2'b10, 16'h5A5A});

    // R10 hard reset in the middle of a frame
    wr(3'd3, 32'h0000_7777);
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", "mdc in mid reset", {63'd0, mdc}, 64'd0);
    check("R10", "oe in mid reset", {63'd0, mdio_oe}, 64'd0);
    rd(3'd5, v); check("R10", "ind in mid reset", {32'd0, v}, 64'd0);
    rd(3'd2, v); check("R10", "addr in mid reset", {32'd0, v}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule